// File: doc/BRIEF.md
# Biphase-Mark Sample-Rate Classifier

This block watches a biphase-mark coded digital audio line and works out which of seven standard sample rates is arriving. A free-running reference clock times the gaps between transitions on the line. The line first passes through a two-flop synchronizer. Inside each measurement window the block keeps the shortest gap it has seen. When the window closes, that shortest gap is placed on a ladder of six configurable thresholds, and the result is a rate code. If no usable gap was seen, the result is a no-signal code.

Configuration arrives as single-cycle register writes on a small write-only port. The host programs the window length, the gap-selection style, the interrupt mask, the per-mode cell timers and the six ladder thresholds. Slot order inside the packed registers is fixed: the lowest mode always sits in the most significant slot. Of the timers, only the one for the fastest mode affects behaviour. It sets the shortest gap that is still treated as real rather than as a glitch.

The block reports three things: the rate code, the measured narrowest gap, and an 8-bit interrupt vector. Bit 2 of the vector marks a change of rate code. The masked OR of the vector drives a single interrupt line.

Top module: `spdif_rate_det`

## Requirements
- R1: While `rst_ni` is low, and after it is released until the first window closes, `mode_o` is 7, `width_o` is 0, `irq_vec_o` is 0 and `irq_o` is 0.
- R2: `mode_o` and `width_o` change only in the cycle after a window closes. A window lasts N reference cycles, where N is the 20-bit window length in address 0 bits [19:0]; a length of 0 acts as 1. Successive output changes are therefore spaced by multiples of N.
- R3: When the select bit (address 0 bit [20]) is 1, gaps are measured between any two transitions. The compare value is twice the narrowest kept gap. The rate code is the lowest i in 0..5 whose threshold is strictly less than the compare value; if there is no such i, the code is 6. The codes 0..6 stand for 32, 44.1, 48, 88.2, 96, 176.4 and 192 kHz.
- R4: When the select bit is 0, gaps are measured between consecutive rising transitions. The compare value is the narrowest such gap itself, not doubled.
- R5: `width_o` reports the narrowest kept gap of the last window, in reference cycles.
- R6: A window that holds no kept gap gives a rate code of 7 and a `width_o` of 0.
- R7: A gap whose compare value is below the fastest-mode timer is discarded as a glitch. That timer is address 2 bits [15:8]. A window that holds only such gaps reports code 7.
- R8: A gap of 1023 reference cycles or more saturates the gap counter and is discarded.
- R9: `irq_vec_o[2]` pulses for one cycle alongside a change of `mode_o`. There is no pulse when the code moves from 7 to 0. All other vector bits stay 0.
- R10: `irq_o` is the OR of `irq_vec_o` ANDed with the 8-bit mask in address 0 bits [28:21].
- R11: The thresholds for modes 0,1,2 sit in address 3, and those for modes 3,4,5 in address 4, at bits [29:20], [19:10] and [9:0] in that order. The timers for modes 0..3 sit in address 1, and those for modes 4..6 in address 2, in bytes [31:24] downward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Biphase-mark serial line, asynchronous |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration register address |
| cfg_wdata_i | input | 32 | Configuration write data |
| mode_o | output | 3 | Detected rate code, 7 = no signal |
| width_o | output | 10 | Narrowest measured gap of the last window |
| irq_vec_o | output | 8 | Interrupt vector, bit 2 = rate change |
| irq_o | output | 1 | Masked interrupt |

## Verification
The bench builds the block with its default parameters: seven modes, 8-bit timers, 10-bit thresholds, a 10-bit gap counter and a 20-bit window count. At run time it writes a 600-cycle window and timers scaled down to between 8 and 48 cycles. This brings the glitch floor, the 1023-cycle saturation point and every rung of the threshold ladder within a few thousand cycles of stimulus. It also makes the window spacing of output changes checkable across the whole run.

// File: rtl/spdif_rd_pkg.sv
package spdif_rd_pkg;
  localparam int unsigned IRQ_CHG_BIT = 2;
  localparam int unsigned CTRL_ADDR   = 0;
  localparam int unsigned TMR_ADDR    = 1;
endpackage

// File: rtl/spdif_rd_cfg.sv
module spdif_rd_cfg
  import spdif_rd_pkg::*;
#(
  parameter int NMODE  = 7,
  parameter int BASE_W = 20,
  parameter int TM_W   = 8,
  parameter int TH_W   = 10,
  parameter int IRQ_W  = 8,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter logic [BASE_W-1:0] BASE_RST = '0
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [BASE_W-1:0]             base_o,
  output logic                          min_sel_o,
  output logic [IRQ_W-1:0]              mask_o,
  output logic [TM_W-1:0]               tmr_fast_o,
  output logic [NMODE-2:0][TH_W-1:0]    thr_o
);
  localparam int NTHR     = NMODE - 1;
  localparam int TM_PER   = DATA_W / TM_W;
  localparam int TH_PER   = DATA_W / TH_W;
  localparam int TM_REGS  = (NMODE + TM_PER - 1) / TM_PER;
  localparam int TH_BASE  = TMR_ADDR + TM_REGS;
  localparam int FAST_RG  = TMR_ADDR + (NMODE - 1) / TM_PER;
  localparam int FAST_SH  = TM_W * (TM_PER - 1 - ((NMODE - 1) % TM_PER));

  // slower-mode timers are not needed by the ladder; only the fastest one is kept
  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o    <= BASE_RST;
      min_sel_o <= 1'b1;
      mask_o    <= '0;
    end else if (we_i && addr_i == ADDR_W'(CTRL_ADDR)) begin
      base_o    <= wdata_i[BASE_W-1:0];
      min_sel_o <= wdata_i[BASE_W];
      mask_o    <= wdata_i[BASE_W+1 +: IRQ_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    tmr_fast_o <= '0;
    else if (we_i && addr_i == ADDR_W'(FAST_RG))    tmr_fast_o <= wdata_i[FAST_SH +: TM_W];
  end

  for (genvar g = 0; g < NTHR; g++) begin : g_thr
    localparam int RG = TH_BASE + g / TH_PER;
    localparam int SH = TH_W * (TH_PER - 1 - (g % TH_PER));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              thr_o[g] <= '0;
      else if (we_i && addr_i == ADDR_W'(RG))   thr_o[g] <= wdata_i[SH +: TH_W];
    end
  end
endmodule

// File: rtl/spdif_rd_meas.sv
module spdif_rd_meas #(
  parameter int BASE_W = 20,
  parameter int IV_W   = 10,
  parameter int TM_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic              min_sel_i,
  input  logic [TM_W-1:0]   tmr_fast_i,
  output logic              win_end_o,
  output logic              win_ok_o,
  output logic [IV_W-1:0]   win_min_o
);
  localparam int CW = IV_W + 1;
  localparam logic [IV_W-1:0] IV_MAX = '1;

  logic [2:0]        sync_q;
  logic              any_edge, rise_edge, qual;
  logic [IV_W-1:0]   ic_q;
  logic [CW-1:0]     cmp;
  logic              keep;
  logic [BASE_W-1:0] cnt_q;
  logic              ok_q;
  logic [IV_W-1:0]   min_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], line_i};
  end

  assign any_edge  = sync_q[2] ^ sync_q[1];
  assign rise_edge = sync_q[1] & ~sync_q[2];
  assign qual      = min_sel_i ? any_edge : rise_edge;

  // gap counter: cycles since last qualifying edge, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ic_q <= IV_MAX;
    else if (qual)            ic_q <= IV_W'(1);
    else if (ic_q != IV_MAX)  ic_q <= ic_q + IV_W'(1);
  end

  assign cmp  = min_sel_i ? {ic_q, 1'b0} : {1'b0, ic_q};
  assign keep = qual && (ic_q != IV_MAX) && (cmp >= CW'(tmr_fast_i));

  assign win_end_o = ({1'b0, cnt_q} + (BASE_W+1)'(1)) >= {1'b0, base_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (win_end_o) cnt_q <= '0;
    else                cnt_q <= cnt_q + BASE_W'(1);
  end

  // candidate includes a gap landing in the closing cycle
  assign win_ok_o  = ok_q | keep;
  assign win_min_o = (keep && (!ok_q || ic_q < min_q)) ? ic_q : min_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ok_q  <= 1'b0;
      min_q <= IV_MAX;
    end else if (win_end_o) begin
      ok_q  <= 1'b0;
      min_q <= IV_MAX;
    end else begin
      ok_q  <= win_ok_o;
      min_q <= win_min_o;
    end
  end

  // R2
  win_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(base_i) |-> (cnt_q < base_i || base_i == '0));

  // R8
  no_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_ok_o |-> win_min_o != IV_MAX);
endmodule

// File: rtl/spdif_rd_class.sv
module spdif_rd_class
  import spdif_rd_pkg::*;
#(
  parameter int NMODE = 7,
  parameter int TH_W  = 10,
  parameter int IV_W  = 10,
  parameter int IRQ_W = 8,
  parameter int MODE_W = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       win_end_i,
  input  logic                       win_ok_i,
  input  logic [IV_W-1:0]            win_min_i,
  input  logic                       min_sel_i,
  input  logic [NMODE-2:0][TH_W-1:0] thr_i,
  input  logic [IRQ_W-1:0]           mask_i,
  output logic [MODE_W-1:0]          mode_o,
  output logic [IV_W-1:0]            width_o,
  output logic [IRQ_W-1:0]           irq_vec_o,
  output logic                       irq_o
);
  localparam int NTHR = NMODE - 1;
  localparam int CW   = IV_W + 1;
  localparam logic [MODE_W-1:0] MODE_NONE = MODE_W'(NMODE);

  logic [CW-1:0]       cmp;
  logic [NTHR-1:0]     hit;
  logic [MODE_W-1:0]   ladder_mode, next_mode;
  logic [MODE_W-1:0]   mode_q;
  logic [IV_W-1:0]     width_q;
  logic [IRQ_W-1:0]    irq_q;
  logic                chg;

  assign cmp = min_sel_i ? {win_min_i, 1'b0} : {1'b0, win_min_i};

  for (genvar g = 0; g < NTHR; g++) begin : g_hit
    assign hit[g] = CW'(thr_i[g]) < cmp;
  end

  // lowest rung wins
  always_comb begin
    ladder_mode = MODE_W'(NMODE - 1);
    for (int i = NTHR - 1; i >= 0; i--)
      if (hit[i]) ladder_mode = MODE_W'(i);
  end

  assign next_mode = win_ok_i ? ladder_mode : MODE_NONE;
  assign chg = (next_mode != mode_q) && !(mode_q == MODE_NONE && next_mode == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_NONE;
      width_q <= '0;
      irq_q   <= '0;
    end else if (win_end_i) begin
      mode_q  <= next_mode;
      width_q <= win_ok_i ? win_min_i : '0;
      irq_q   <= '0;
      irq_q[IRQ_CHG_BIT] <= chg;
    end else begin
      irq_q   <= '0;
    end
  end

  assign mode_o    = mode_q;
  assign width_o   = width_q;
  assign irq_vec_o = irq_q;
  assign irq_o     = |(irq_q & mask_i);

  // R2
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(win_end_i) |-> ($stable(mode_q) && $stable(width_q)));

  // R6
  none_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_NONE) |-> (width_q == '0));

  // R9
  irq_chg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q[IRQ_CHG_BIT] |-> (mode_q != $past(mode_q)));

  // R9
  irq_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q[IRQ_CHG_BIT] |-> !($past(mode_q) == MODE_NONE && mode_q == '0));

  // R9
  irq_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(irq_q) <= 1);
endmodule

// File: rtl/spdif_rate_det.sv
module spdif_rate_det #(
  parameter int NMODE  = 7,
  parameter int BASE_W = 20,
  parameter int TM_W   = 8,
  parameter int TH_W   = 10,
  parameter int IV_W   = 10,
  parameter int IRQ_W  = 8,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int MODE_W = $clog2(NMODE + 1),
  parameter logic [BASE_W-1:0] BASE_RST = BASE_W'(333333)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [MODE_W-1:0] mode_o,
  output logic [IV_W-1:0]   width_o,
  output logic [IRQ_W-1:0]  irq_vec_o,
  output logic              irq_o
);
  logic [BASE_W-1:0]          base;
  logic                       min_sel;
  logic [IRQ_W-1:0]           mask;
  logic [TM_W-1:0]            tmr_fast;
  logic [NMODE-2:0][TH_W-1:0] thr;
  logic                       win_end, win_ok;
  logic [IV_W-1:0]            win_min;

  spdif_rd_cfg #(
    .NMODE(NMODE), .BASE_W(BASE_W), .TM_W(TM_W), .TH_W(TH_W),
    .IRQ_W(IRQ_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_RST(BASE_RST)
  ) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i), .base_o(base), .min_sel_o(min_sel),
    .mask_o(mask), .tmr_fast_o(tmr_fast), .thr_o(thr)
  );

  spdif_rd_meas #(.BASE_W(BASE_W), .IV_W(IV_W), .TM_W(TM_W)) u_meas (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(line_i), .base_i(base),
    .min_sel_i(min_sel), .tmr_fast_i(tmr_fast), .win_end_o(win_end),
    .win_ok_o(win_ok), .win_min_o(win_min)
  );

  spdif_rd_class #(
    .NMODE(NMODE), .TH_W(TH_W), .IV_W(IV_W), .IRQ_W(IRQ_W), .MODE_W(MODE_W)
  ) u_class (
    .clk_i(clk_i), .rst_ni(rst_ni), .win_end_i(win_end), .win_ok_i(win_ok),
    .win_min_i(win_min), .min_sel_i(min_sel), .thr_i(thr), .mask_i(mask),
    .mode_o(mode_o), .width_o(width_o), .irq_vec_o(irq_vec_o), .irq_o(irq_o)
  );
endmodule

// File: tb/spdif_rate_det_tb.sv
module spdif_rate_det_tb;
  localparam int WIN = 600;
  localparam int T6  = 8;
  localparam int TH[6] = '{83, 67, 49, 33, 25, 17};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [2:0]  mode_o;
  logic [9:0]  width_o;
  logic [7:0]  irq_vec_o;
  logic        irq_o;

  int  n_chk = 0, n_err = 0;
  int  vec_cnt = 0, irq_cnt = 0;
  bit  pat_on = 0;
  int  pat_w = 8;
  bit  cur_sel = 1;
  logic [7:0] cur_mask = 8'hff;
  longint cyc = 0, last_chg = -1;
  logic [2:0] pm = 3'd7;
  logic [9:0] pw = '0;
  bit  mon_on = 0;

  always #2 clk = ~clk;

  spdif_rate_det u_dut (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .cfg_we_i(we),
    .cfg_addr_i(addr), .cfg_wdata_i(wdata), .mode_o(mode_o),
    .width_o(width_o), .irq_vec_o(irq_vec_o), .irq_o(irq_o)
  );

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (irq_vec_o[2]) vec_cnt++;
    if (irq_o) irq_cnt++;
    if (mon_on && (mode_o !== pm || width_o !== pw)) begin
      if (last_chg >= 0) check("R2 change spacing mod window", (cyc - last_chg) % WIN, 0);
      last_chg = cyc;
    end
    pm = mode_o;
    pw = width_o;
  end

  // gaps alternate w, 2w; rising-to-rising gap is 3w
  initial begin
    forever begin
      if (pat_on) begin
        int w;
        w = pat_w;
        repeat (w) @(negedge clk);
        line = ~line;
        repeat (2 * w) @(negedge clk);
        line = ~line;
      end else @(negedge clk);
    end
  end

  function automatic void expect_res(int w, bit sel, output int m, output int wd);
    int ivs[2];
    int n;
    int best;
    best = -1;
    if (sel) begin ivs[0] = w; ivs[1] = 2 * w; n = 2; end
    else begin ivs[0] = 3 * w; ivs[1] = 0; n = 1; end
    for (int k = 0; k < n; k++) begin
      int v;
      v = sel ? 2 * ivs[k] : ivs[k];
      if (ivs[k] < 1023 && v >= T6 && (best < 0 || ivs[k] < best)) best = ivs[k];
    end
    if (best < 0) begin m = 7; wd = 0; end
    else begin
      int v;
      v = sel ? 2 * best : best;
      m = 6;
      for (int i = 5; i >= 0; i--) if (TH[i] < v) m = i;
      wd = best;
    end
  endfunction

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic set_ctrl(bit sel, logic [7:0] mask);
    cur_sel = sel;
    cur_mask = mask;
    wr(3'd0, {3'b0, mask, sel, 20'(WIN)});
  endtask

  task automatic play(int w);
    pat_w = w;
    pat_on = 1;
    repeat (3 * WIN + 10) @(negedge clk);
  endtask

  task automatic quiet();
    pat_on = 0;
    repeat (3 * WIN + 10 + 3 * pat_w) @(negedge clk);
  endtask

  task automatic run_case(string req, int w, bit sel);
    int m, wd;
    if (sel != cur_sel) set_ctrl(sel, cur_mask);
    expect_res(w, sel, m, wd);
    play(w);
    check({req, " mode"}, mode_o, m);
    check({req, " width R5"}, width_o, wd);
    quiet();
  endtask

  task automatic main_seq();
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 mode in reset", mode_o, 7);
    check("R1 irq_vec in reset", irq_vec_o, 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 mode after reset", mode_o, 7);
    check("R1 width after reset", width_o, 0);
    check("R1 irq after reset", irq_o, 0);

    // R11 packed layout: timer 6 in addr2 [15:8]; thresholds MSB slot first
    set_ctrl(1'b1, 8'hff);
    wr(3'd1, {8'd48, 8'd35, 8'd32, 8'd17});
    wr(3'd2, {8'd16, 8'd9, 8'(T6), 8'd0});
    wr(3'd3, {2'b0, 10'(TH[0]), 10'(TH[1]), 10'(TH[2])});
    wr(3'd4, {2'b0, 10'(TH[3]), 10'(TH[4]), 10'(TH[5])});
    mon_on = 1;
    repeat (2 * WIN) @(negedge clk);

    // R9: none -> mode 0 gives no interrupt
    vec_cnt = 0; irq_cnt = 0;
    run_case("R3", 48, 1'b1);
    check("R6 silence mode", mode_o, 7);
    check("R6 silence width", width_o, 0);
    check("R9 one pulse only for 0->7", vec_cnt, 1);
    play(17);
    check("R9 mode 3 reached", mode_o, 3);
    check("R9 pulse on 7->3", vec_cnt, 2);
    check("R10 masked-in irq", irq_cnt, 2);
    set_ctrl(1'b1, 8'h00);
    quiet();
    check("R9 pulse on 3->7", vec_cnt, 3);
    check("R10 mask zero blocks irq", irq_cnt, 2);
    set_ctrl(1'b1, 8'h04);

    // R3 / R11: every rung of the ladder
    run_case("R3 R11 mode0", 48, 1'b1);
    run_case("R3 R11 mode1", 35, 1'b1);
    run_case("R3 R11 mode2", 32, 1'b1);
    run_case("R3 R11 mode3", 17, 1'b1);
    run_case("R3 R11 mode4", 16, 1'b1);
    run_case("R3 R11 mode5", 9, 1'b1);
    run_case("R3 R11 mode6", 8, 1'b1);
    // R7 glitch floor
    run_case("R7 short w=3", 3, 1'b1);
    run_case("R7 only glitches", 1, 1'b1);
    run_case("R7 rise glitch", 2, 1'b0);
    // R8 saturation
    run_case("R8 saturated gaps", 1100, 1'b1);
    // R4 rising-edge select
    run_case("R4 rise", 11, 1'b0);
    run_case("R4 rise", 20, 1'b0);

    for (int k = 0; k < 10; k++) begin
      int w;
      bit s;
      w = 4 + int'($urandom % 57);
      s = 1'($urandom % 2);
      run_case(s ? "R3 random" : "R4 random", w, s);
    end
  endtask

  initial begin
    void'($urandom(32'd13));
    fork
      main_seq();
      begin
        repeat (190000) @(negedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog R2: actual hung expected finished");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule